// File: doc/BRIEF.md
# Card Storage Controller Host Register Interface

This block is the device-facing side of a small memory-mapped register set through which a host processor drives a removable storage card. The host reads and writes 16-bit registers on a simple strobe bus. The registers cover bus width selection, status, error, block address, a combined sector count and command word, a version code and a control word. A 32-byte window moves sector data.

Before it can issue card commands or move data, the host must win a lock. It does this by setting a request bit and waiting for a granted flag. It then writes a command. A behavioural card model behind the registers becomes busy for a fixed latency and then presents one 32-byte buffer. The host drains or fills that buffer through the window. The model then re-arms for the next buffer, and it repeats this sixteen times for each 512-byte sector.

A level interrupt can be raised when a buffer becomes ready or when an error occurs. Software acknowledges it by setting a control bit and then clearing it.

Top module: `cardstor_host_regs`

## Requirements
- R1: After reset the status low half (byte offset 0x04) reads 0x0110 with a card present: bit 4 card present and bit 8 ready for a command. The status high half (0x06), the error register (0x08), the bus mode register (0x00) and `irq` are all zero.
- R2: Control bit 1 requests the lock. Status bit 1 (granted) rises LOCK_LAT cycles after the request is stored and falls one cycle after the request is cleared. Without the grant, command writes and window accesses have no effect.
- R3: The host block address is two halves: low at 0x10 and high at 0x12. Only bits 11:0 of the high half are kept, which gives 28 significant bits. The control word (0x18) and the count/command word (0x14) read back exactly as written.
- R4: The version register (0x16) reads the VERSION parameter: major in bits 15:12, minor in bits 11:8, revision in bits 7:0. It never reads as 0x0000 or 0xFFFF.
- R5: A bus mode write with bit 0 set (for example 0x0101) selects 16-bit window accesses, and the register then reads 0x0001. Writing bit 0 clear selects 8-bit accesses and the register reads 0x0000.
- R6: The command code sits in bits 15:8 of 0x14 (1 reset, 2 identify, 3 read, 4 write, 6 abort) and the sector count sits in bits 7:0. A valid identify, read or write sets status bit 17 (busy) and clears bit 8. Bit 17 and status bit 5 (buffer ready) are never set together.
- R7: Each buffer holds 32 bytes: 16 accesses in 16-bit mode, 32 in 8-bit mode. Bit 5 stays set until the last access and drops right after it. A sector is 16 buffers. After the final buffer, bit 8 returns. Window reads without a ready buffer return 0.
- R8: Read data follows the pattern byte k = k[7:0] XOR LBA[7:0], where k counts from 0 over the whole transfer. In 16-bit mode byte k is in bits 7:0 and byte k+1 is in bits 15:8. In 8-bit mode bits 15:8 are zero.
- R9: Identify delivers exactly one sector using the same pattern with seed 0x5A. After that the card stays idle.
- R10: An unknown command code, or a read or write with count 0, sets status bit 3 and error register bit 0. A reset command clears that error. An abort issued during a transfer returns the card to idle.
- R11: `irq` rises when a buffer becomes ready and control bit 8 is set. It also rises when the card error appears and control bit 9 is set. It does not rise for either event when the matching enable bit is clear.
- R12: Once set, `irq` holds through any window accesses and while control bit 11 is 1. It clears only after bit 11 goes from 1 back to 0.
- R13: With `card_present` low, status bits 4 and 8 read 0 and commands are ignored. If the card is removed during a transfer, the transfer is dropped and the card goes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 7 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, advances the data window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| card_present | input | 1 | Card inserted in the slot |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is the interrupt that is pending while software acknowledges it, especially alongside an abort issued mid-transfer. Reaching it requires taking the lock, starting a read, polling until a buffer is ready, aborting, and then stepping the clear bit through 1 and 0. The bench follows exactly that sequence and samples `irq` after each step. Pulling the card out during a busy phase is the second hard case. The bench drops `card_present` for one cycle while busy is set and confirms through status that the transfer was abandoned.

// File: rtl/shi_pkg.sv
// Shared constants for the card storage host register interface.
// Assumes a 7-bit byte address space and 16-bit register accesses.
package shi_pkg;
    localparam int BUF_BYTES       = 32;
    localparam int SECTOR_BYTES    = 512;
    localparam int BUFS_PER_SECTOR = SECTOR_BYTES / BUF_BYTES;

    // register byte offsets
    localparam logic [6:0] OFS_MODE    = 7'h00;
    localparam logic [6:0] OFS_STAT_LO = 7'h04;
    localparam logic [6:0] OFS_STAT_HI = 7'h06;
    localparam logic [6:0] OFS_ERR     = 7'h08;
    localparam logic [6:0] OFS_LBA_LO  = 7'h10;
    localparam logic [6:0] OFS_LBA_HI  = 7'h12;
    localparam logic [6:0] OFS_CMD     = 7'h14;
    localparam logic [6:0] OFS_VER     = 7'h16;
    localparam logic [6:0] OFS_CTRL    = 7'h18;

    // status bit positions
    localparam int ST_GRANT   = 1;
    localparam int ST_CFGERR  = 2;
    localparam int ST_CARDERR = 3;
    localparam int ST_PRESENT = 4;
    localparam int ST_BUFRDY  = 5;
    localparam int ST_CMDRDY  = 8;
    localparam int ST_BUSY    = 17;

    // control bit positions
    localparam int CT_LOCKREQ = 1;
    localparam int CT_BUFIE   = 8;
    localparam int CT_ERRIE   = 9;
    localparam int CT_IRQCLR  = 11;

    // command codes (upper byte of the count/command word)
    localparam logic [7:0] OP_RESET = 8'd1;
    localparam logic [7:0] OP_IDENT = 8'd2;
    localparam logic [7:0] OP_READ  = 8'd3;
    localparam logic [7:0] OP_WRITE = 8'd4;
    localparam logic [7:0] OP_ABORT = 8'd6;

    localparam logic [7:0] IDENT_SEED = 8'h5A;

    typedef enum logic [1:0] {CS_IDLE, CS_BUSY, CS_READY} card_st_e;
endpackage

// File: rtl/shi_lock_arb.sv
// Host lock arbiter: grants the lock LAT cycles after the request is
// seen and withdraws it the cycle after the request goes away.
// Assumes LAT >= 1.
module shi_lock_arb #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic grant
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;

    // count request age, raise grant at the latency limit
    always_ff @(posedge clk) begin
        if (!rst_n || !req) begin
            cnt   <= '0;
            grant <= 1'b0;
        end else if (!grant) begin
            if (cnt == CW'(LAT - 1)) grant <= 1'b1;
            else                     cnt   <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/shi_irq_ctl.sv
// Interrupt pending flag: set on a rising enabled cause, held while the
// clear bit is high, dropped when the clear bit returns low.
module shi_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic src_buf,
    input  logic src_err,
    input  logic en_buf,
    input  logic en_err,
    input  logic clr,
    output logic irq
);
    logic cause, cause_q, clr_q;

    // combine the enabled sources
    always_comb cause = (src_buf && en_buf) || (src_err && en_err);

    // edge tracking and pending flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= 1'b0;
            clr_q   <= 1'b0;
            irq     <= 1'b0;
        end else begin
            cause_q <= cause;
            clr_q   <= clr;
            if (clr_q && !clr)               irq <= 1'b0;
            else if (!clr && cause && !cause_q) irq <= 1'b1;
        end
    end
endmodule

// File: rtl/shi_card_model.sv
// Behavioural card: accepts commands, stays busy BUSY_LAT cycles per
// buffer, then exposes a 32-byte buffer consumed by window accesses.
// Assumes cmd_go and win_acc are already qualified by lock and presence.
module shi_card_model
    import shi_pkg::*;
#(
    parameter int BUSY_LAT = 8,
    parameter int MAX_SECT = 255
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        present,
    input  logic        wide,
    input  logic        cmd_go,
    input  logic [7:0]  cmd_op,
    input  logic [7:0]  cmd_cnt,
    input  logic [7:0]  seed_in,
    input  logic        win_acc,
    output logic        busy,
    output logic        buf_rdy,
    output logic        cmd_rdy,
    output logic        card_err,
    output logic [15:0] rd_word
);
    localparam int BUFW = $clog2(MAX_SECT * BUFS_PER_SECTOR + 1);
    localparam int LW   = $clog2(BUSY_LAT + 1);
    localparam int BW   = $clog2(BUF_BYTES + 1);

    card_st_e       st;
    logic [LW-1:0]  lat;
    logic [BUFW-1:0] bufs;
    logic [BW-1:0]  fill;
    logic [BW-1:0]  step;
    logic [7:0]     pos, seed;
    logic           last_acc;

    // bytes per access and end-of-buffer detection
    always_comb begin
        step     = wide ? BW'(2) : BW'(1);
        last_acc = (fill + step) >= BW'(BUF_BYTES);
    end

    // card state sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= CS_IDLE;
            lat      <= '0;
            bufs     <= '0;
            fill     <= '0;
            pos      <= '0;
            seed     <= '0;
            card_err <= 1'b0;
        end else if (!present) begin
            st   <= CS_IDLE;
            bufs <= '0;
        end else if (cmd_go && st != CS_IDLE &&
                     (cmd_op == OP_ABORT || cmd_op == OP_RESET)) begin
            st   <= CS_IDLE;
            bufs <= '0;
            if (cmd_op == OP_RESET) card_err <= 1'b0;
        end else begin
            case (st)
                CS_IDLE: begin
                    if (cmd_go) begin
                        case (cmd_op)
                            OP_RESET: card_err <= 1'b0;
                            OP_ABORT: ;
                            OP_IDENT: begin
                                bufs <= BUFW'(BUFS_PER_SECTOR);
                                seed <= IDENT_SEED;
                                st   <= CS_BUSY;
                                lat  <= '0;
                                pos  <= '0;
                            end
                            OP_READ, OP_WRITE: begin
                                if (cmd_cnt == 8'd0) begin
                                    card_err <= 1'b1;
                                end else begin
                                    bufs <= BUFW'(cmd_cnt) * BUFW'(BUFS_PER_SECTOR);
                                    seed <= seed_in;
                                    st   <= CS_BUSY;
                                    lat  <= '0;
                                    pos  <= '0;
                                end
                            end
                            default: card_err <= 1'b1;
                        endcase
                    end
                end
                CS_BUSY: begin
                    if (lat == LW'(BUSY_LAT - 1)) begin
                        st   <= CS_READY;
                        fill <= '0;
                    end else begin
                        lat <= lat + 1'b1;
                    end
                end
                CS_READY: begin
                    if (win_acc) begin
                        pos <= pos + 8'(step);
                        if (last_acc) begin
                            fill <= '0;
                            bufs <= bufs - 1'b1;
                            lat  <= '0;
                            st   <= (bufs == BUFW'(1)) ? CS_IDLE : CS_BUSY;
                        end else begin
                            fill <= fill + step;
                        end
                    end
                end
                default: st <= CS_IDLE;
            endcase
        end
    end

    // status flags and generated read data
    always_comb begin
        busy    = (st == CS_BUSY);
        buf_rdy = (st == CS_READY);
        cmd_rdy = (st == CS_IDLE) && present;
        rd_word = wide ? {(pos + 8'd1) ^ seed, pos ^ seed} : {8'h00, pos ^ seed};
    end
endmodule

// File: rtl/cardstor_host_regs.sv
// Host register interface for a card storage controller. Decodes the
// register map, stores host-writable fields, qualifies commands and data
// window accesses by the lock grant, and instantiates the lock arbiter,
// the card model and the interrupt logic.
// Assumes one 16-bit access per strobe cycle, even byte offsets.
module cardstor_host_regs
    import shi_pkg::*;
#(
    parameter int          LOCK_LAT = 4,
    parameter int          BUSY_LAT = 8,
    parameter logic [15:0] VERSION  = 16'h1203
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        card_present,
    output logic        irq
);
    logic        wide;
    logic [27:0] lba;
    logic [15:0] cmd_reg, ctrl;
    logic        grant, busy, buf_rdy, cmd_rdy, card_err;
    logic [15:0] win_word;
    logic [31:0] status;
    logic        win_hit, win_acc, cmd_go;
    logic        lock_req, irq_clr, buf_ie, err_ie;

    // control field breakout
    always_comb begin
        lock_req = ctrl[CT_LOCKREQ];
        irq_clr  = ctrl[CT_IRQCLR];
        buf_ie   = ctrl[CT_BUFIE];
        err_ie   = ctrl[CT_ERRIE];
    end

    // access qualification
    always_comb begin
        win_hit = (bus_addr[6:5] == 2'b10);
        win_acc = win_hit && (bus_rd || bus_wr) && grant && buf_rdy;
        cmd_go  = bus_wr && (bus_addr == OFS_CMD) && grant && card_present;
    end

    // host-writable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide    <= 1'b0;
            lba     <= '0;
            cmd_reg <= '0;
            ctrl    <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_MODE:   wide       <= bus_wdata[0];
                OFS_LBA_LO: lba[15:0]  <= bus_wdata;
                OFS_LBA_HI: lba[27:16] <= bus_wdata[11:0];
                OFS_CMD:    cmd_reg    <= bus_wdata;
                OFS_CTRL:   ctrl       <= bus_wdata;
                default: ;
            endcase
        end
    end

    // status word assembly
    always_comb begin
        status             = '0;
        status[ST_GRANT]   = grant;
        status[ST_CFGERR]  = 1'b0;
        status[ST_CARDERR] = card_err;
        status[ST_PRESENT] = card_present;
        status[ST_BUFRDY]  = buf_rdy;
        status[ST_CMDRDY]  = cmd_rdy;
        status[ST_BUSY]    = busy;
    end

    // read data selection
    always_comb begin
        case (bus_addr)
            OFS_MODE:    bus_rdata = {15'd0, wide};
            OFS_STAT_LO: bus_rdata = status[15:0];
            OFS_STAT_HI: bus_rdata = status[31:16];
            OFS_ERR:     bus_rdata = {15'd0, card_err};
            OFS_LBA_LO:  bus_rdata = lba[15:0];
            OFS_LBA_HI:  bus_rdata = {4'd0, lba[27:16]};
            OFS_CMD:     bus_rdata = cmd_reg;
            OFS_VER:     bus_rdata = VERSION;
            OFS_CTRL:    bus_rdata = ctrl;
            default:     bus_rdata = (win_hit && buf_rdy && grant) ? win_word : 16'h0000;
        endcase
    end

    shi_lock_arb #(.LAT(LOCK_LAT)) i_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lock_req),
        .grant (grant)
    );

    shi_card_model #(.BUSY_LAT(BUSY_LAT)) i_card (
        .clk      (clk),
        .rst_n    (rst_n),
        .present  (card_present),
        .wide     (wide),
        .cmd_go   (cmd_go),
        .cmd_op   (bus_wdata[15:8]),
        .cmd_cnt  (bus_wdata[7:0]),
        .seed_in  (lba[7:0]),
        .win_acc  (win_acc),
        .busy     (busy),
        .buf_rdy  (buf_rdy),
        .cmd_rdy  (cmd_rdy),
        .card_err (card_err),
        .rd_word  (win_word)
    );

    shi_irq_ctl i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_buf (buf_rdy),
        .src_err (card_err),
        .en_buf  (buf_ie),
        .en_err  (err_ie),
        .clr     (irq_clr),
        .irq     (irq)
    );
endmodule

// File: rtl/shi_host_regs_chk.sv
// Protocol checker bound to the host register interface.
module shi_host_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lock_req,
    input logic        grant,
    input logic        buf_rdy,
    input logic        busy,
    input logic        irq,
    input logic        irq_clr,
    input logic        buf_ie,
    input logic        err_ie,
    input logic        card_err,
    input logic        bus_rd,
    input logic [6:0]  bus_addr,
    input logic [15:0] bus_rdata,
    input logic        win_hit
);
    // R2
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_req |=> !grant);

    // R6
    rdy_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rdy && busy));

    // R12
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_clr) |=> !irq);

    // R4
    version_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 7'h16) |-> (bus_rdata != 16'h0000 && bus_rdata != 16'hFFFF));

    // R7
    win_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !buf_rdy) |-> bus_rdata == 16'h0000);

    // R11
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((buf_rdy && buf_ie) || (card_err && err_ie)));
endmodule

bind cardstor_host_regs shi_host_regs_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_req  (lock_req),
    .grant     (grant),
    .buf_rdy   (buf_rdy),
    .busy      (busy),
    .irq       (irq),
    .irq_clr   (irq_clr),
    .buf_ie    (buf_ie),
    .err_ie    (err_ie),
    .card_err  (card_err),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .win_hit   (win_hit)
);

// File: tb/test_cardstor_host_regs.sv
module test_cardstor_host_regs;
    localparam int LOCK_LAT = 4;
    localparam logic [6:0] A_MODE = 7'h00, A_SLO = 7'h04, A_SHI = 7'h06, A_ERR = 7'h08,
                           A_LLO = 7'h10, A_LHI = 7'h12, A_CMD = 7'h14, A_VER = 7'h16,
                           A_CTRL = 7'h18, A_WIN = 7'h40;

    // {write addr, write data, read addr, expected}
    localparam logic [63:0] VEC [8] = '{
        {16'h0010, 16'hBEEF, 16'h0010, 16'hBEEF},
        {16'h0012, 16'hF123, 16'h0012, 16'h0123},
        {16'h0018, 16'h0300, 16'h0018, 16'h0300},
        {16'h0000, 16'h0101, 16'h0000, 16'h0001},
        {16'h0000, 16'h0000, 16'h0000, 16'h0000},
        {16'h0014, 16'h0301, 16'h0004, 16'h0110},
        {16'h0014, 16'h0305, 16'h0014, 16'h0305},
        {16'h0018, 16'h0000, 16'h0018, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic card_present = 1'b1;
    logic irq;
    int n_chk = 0, n_bad = 0;
    logic [15:0] v;

    always #5 clk = ~clk;

    cardstor_host_regs i_cardstor_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_present(card_present), .irq(irq)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2, 6, 7: return "R3 register store";
            3, 4:          return "R5 bus mode";
            default:       return "R2 command without lock";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_buf(output bit ok);
        logic [15:0] s;
        ok = 1'b0;
        for (int i = 0; i < 100; i++) begin
            rd(A_SLO, s);
            if (s[5]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic drain(input bit do_write, input logic [7:0] seed, input bit w16,
                         input int nbuf, input string tag);
        bit ok;
        int k = 0;
        int acc = w16 ? 16 : 32;
        logic [15:0] d, e;
        logic [7:0] kb;
        for (int b = 0; b < nbuf; b++) begin
            wait_buf(ok);
            check({tag, " buffer ready"}, ok, 1);
            for (int a = 0; a < acc; a++) begin
                kb = k[7:0];
                if (do_write) begin
                    wr(A_WIN, {8'h00, kb});
                end else begin
                    rd(A_WIN, d);
                    e = w16 ? {(kb + 8'd1) ^ seed, kb ^ seed} : {8'h00, kb ^ seed};
                    check({tag, " data"}, d, e);
                end
                k += w16 ? 2 : 1;
                if (b == 0 && a == acc - 2) begin
                    rd(A_SLO, d);
                    check("R7 ready held before last access", d[5], 1);
                end
            end
            rd(A_SLO, d);
            check("R7 ready drops after last access", d[5], 0);
        end
    endtask

    // watchdog
    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_SLO, v);  check("R1 status low", v, 16'h0110);
        rd(A_SHI, v);  check("R1 status high", v, 16'h0000);
        rd(A_ERR, v);  check("R1 error", v, 16'h0000);
        rd(A_MODE, v); check("R1 bus mode", v, 16'h0000);
        check("R1 irq", irq, 0);
        rd(A_VER, v);  check("R4 version", v, 16'h1203);

        // table walk
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][54:48], VEC[i][47:32]);
            rd(VEC[i][22:16], v);
            check(vec_tag(i), v, VEC[i][15:0]);
        end

        // R2 lock latency
        wr(A_CTRL, 16'h0002);
        rd(A_SLO, v); check("R2 grant not yet", v[1], 0);
        repeat (LOCK_LAT) @(negedge clk);
        rd(A_SLO, v); check("R2 grant raised", v, 16'h0112);

        // R8 wide read, one sector
        wr(A_LLO, 16'h1237); wr(A_LHI, 16'h0000);
        wr(A_MODE, 16'h0101);
        wr(A_CMD, 16'h0301);
        rd(A_SHI, v); check("R6 busy set", v, 16'h0002);
        rd(A_SLO, v); check("R6 ready for command cleared", v, 16'h0012);
        drain(1'b0, 8'h37, 1'b1, 16, "R8");
        rd(A_SLO, v); check("R7 idle after sector", v, 16'h0112);

        // R9 identify in 8-bit mode
        wr(A_MODE, 16'h0000);
        wr(A_CMD, 16'h0200);
        drain(1'b0, 8'h5A, 1'b0, 16, "R9");
        repeat (20) @(negedge clk);
        rd(A_SLO, v); check("R9 identify ends after one sector", v, 16'h0112);

        // write two sectors, wide
        wr(A_MODE, 16'h0101);
        wr(A_CMD, 16'h0402);
        drain(1'b1, 8'h00, 1'b1, 32, "R7 write");
        rd(A_SLO, v); check("R7 write complete", v, 16'h0112);

        // R11 / R12 buffer interrupt with abort and clear pulse
        wr(A_CTRL, 16'h0102);
        wr(A_CMD, 16'h0301);
        begin
            bit ok;
            wait_buf(ok);
            check("R11 buffer ready for irq", ok, 1);
        end
        repeat (2) @(negedge clk);
        check("R11 buffer irq", irq, 1);
        wr(A_CMD, 16'h0600);
        rd(A_SLO, v); check("R10 abort to idle", v, 16'h0112);
        check("R12 irq held after abort", irq, 1);
        wr(A_CTRL, 16'h0902);
        repeat (2) @(negedge clk);
        check("R12 irq held while clear high", irq, 1);
        wr(A_CTRL, 16'h0102);
        repeat (2) @(negedge clk);
        check("R12 irq cleared", irq, 0);

        // R10 / R11 errors
        wr(A_CTRL, 16'h0002);
        wr(A_CMD, 16'h0900);
        rd(A_SLO, v); check("R10 unknown command error", v, 16'h011A);
        rd(A_ERR, v); check("R10 error register", v, 16'h0001);
        check("R11 error irq disabled", irq, 0);
        wr(A_CMD, 16'h0100);
        rd(A_SLO, v); check("R10 reset clears error", v, 16'h0112);
        wr(A_CTRL, 16'h0202);
        wr(A_CMD, 16'h0300);
        rd(A_SLO, v); check("R10 zero count error", v, 16'h011A);
        check("R11 error irq enabled", irq, 1);
        wr(A_CTRL, 16'h0A02);
        wr(A_CTRL, 16'h0202);
        repeat (2) @(negedge clk);
        check("R12 error irq cleared", irq, 0);
        wr(A_CMD, 16'h0100);

        // R2 release lock, commands ignored
        wr(A_CTRL, 16'h0000);
        rd(A_SLO, v); check("R2 grant released", v, 16'h0110);
        wr(A_CMD, 16'h0301);
        rd(A_SHI, v); check("R2 command ignored unlocked", v, 16'h0000);

        // R13 card absent
        card_present = 1'b0;
        rd(A_SLO, v); check("R13 absent status", v, 16'h0000);
        wr(A_CTRL, 16'h0002);
        repeat (LOCK_LAT + 1) @(negedge clk);
        wr(A_CMD, 16'h0301);
        rd(A_SHI, v); check("R13 command ignored absent", v, 16'h0000);
        rd(A_SLO, v); check("R13 absent with lock", v, 16'h0002);
        card_present = 1'b1;
        wr(A_CMD, 16'h0301);
        rd(A_SHI, v); check("R13 busy before removal", v, 16'h0002);
        @(negedge clk); card_present = 1'b0;
        @(negedge clk); card_present = 1'b1;
        rd(A_SHI, v); check("R13 transfer dropped", v, 16'h0000);
        rd(A_SLO, v); check("R13 idle after removal", v, 16'h0112);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule